// File: doc/BRIEF.md
# Write-Back Byte Cache with Dirty Eviction

This block is a small data cache that sits between a processor's byte load/store port and a slower block-oriented memory. It keeps a few fully associative lines, each holding a whole multi-byte block together with a valid flag, a modified flag and a block tag. Stores update only the cached copy and mark the line modified. Memory sees a write only when a modified line has to make room for another block, or when an explicit flush drains the cache. Every miss allocates a line, including a store miss, and the line is always filled with the complete block from memory.

A request is taken when `req_valid` and `req_ready` are both high. A hit is answered on the next cycle. A miss drops `req_ready` while the controller writes back a modified victim, if there is one, and then fetches the new block. The request is completed once the fill has arrived. A flush pulse walks the lines in index order, writes back every modified one, invalidates the whole array and reports completion with a one-cycle pulse. Three counters show how many requests hit, how many missed, and how many blocks were written back.

Top module: `wbc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, all three counters read 0, and every line is invalid.
- R2: A load that hits returns the addressed byte on `resp_rdata` with `resp_valid` one cycle after acceptance, and causes no memory request.
- R3: A store, whether it hits or misses, writes only the cached copy and sets the line's modified flag. Its response echoes the stored byte. No memory write happens at the time of the store.
- R4: On a miss the controller reads the whole block at block address `req_addr[4:1]`, with byte offset 0 in `mem_rdata[7:0]`. It installs the block as valid and unmodified, then completes the access.
- R5: When the victim line is modified, the controller writes the complete victim block to the victim's block address before it starts the fill read. A clean victim is dropped with no memory write.
- R6: The victim is the lowest-numbered invalid line. If every line is valid, the victim is the least recently used line.
- R7: `req_ready` stays 0 from a miss until its completing cycle. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R8: `hit_count`, `miss_count` and `wb_count` each step by one per hit, per miss, and per block written to memory.
- R9: A flush writes back the modified lines in ascending line order and then invalidates all lines. It raises `flush_done` for exactly one cycle, and the next access misses.
- R10: From an empty cache, the accesses load 1, load 7, store 0, store 5, load 10, store 5, store 10 give 4 misses, 3 hits and exactly one dirty eviction. Both lines are left modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 8 | Loaded byte, or stored byte echoed back |
| flush | input | 1 | Start a flush of all lines |
| flush_done | output | 1 | One-cycle pulse when the flush completes |
| mem_req | output | 1 | Memory block transfer requested |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 4 | Block address |
| mem_wdata | output | 16 | Block written back, byte 0 in the low bits |
| mem_rdata | input | 16 | Block returned by memory |
| mem_ack | input | 1 | Transfer complete |
| hit_count | output | 16 | Hits so far |
| miss_count | output | 16 | Misses so far |
| wb_count | output | 16 | Blocks written back so far |

## Verification
The bench targets a dirty eviction. A design that wrote only the modified byte, or that issued the fill before the write-back, leaves the wrong contents in memory or records the operations in the wrong order. It also checks that a store hit leaves memory untouched, which a write-through slip would break. To exercise LRU choice, it refills a line and then re-touches one block, so that picking the wrong victim shows up as an extra miss. A flush must write both modified lines in line order and leave the array empty, so that a stale valid flag would turn the next access into a hit.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WRITEBACK = 3'd1,
    ST_FILL      = 3'd2,
    ST_RESPOND   = 3'd3,
    ST_FSCAN     = 3'd4,
    ST_FWB       = 3'd5
  } wbc_state_e;
endpackage

// File: rtl/wbc_lines.sv
module wbc_lines #(
  parameter int LINES     = 2,
  parameter int TAG_W     = 4,
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 2,
  parameter int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1,
  parameter int OFS_W     = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [TAG_W-1:0]                     lk_tag,
  output logic                                 lk_hit,
  output logic [IDX_W-1:0]                     lk_idx,
  input  logic                                 fill_en,
  input  logic [IDX_W-1:0]                     fill_idx,
  input  logic [TAG_W-1:0]                     fill_tag,
  input  logic [BLK_BYTES-1:0][BYTE_W-1:0]     fill_data,
  input  logic                                 st_en,
  input  logic [IDX_W-1:0]                     st_idx,
  input  logic [OFS_W-1:0]                     st_ofs,
  input  logic [BYTE_W-1:0]                    st_byte,
  input  logic                                 inv_en,
  input  logic [IDX_W-1:0]                     inv_idx,
  input  logic                                 clr_all,
  output logic [LINES-1:0]                     valid_o,
  output logic [LINES-1:0]                     dirty_o,
  output logic [TAG_W-1:0]                     tag_o  [LINES],
  output logic [BLK_BYTES-1:0][BYTE_W-1:0]     data_o [LINES]
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_BYTES-1:0][BYTE_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_fill, sel_st, sel_inv;
    assign sel_fill = fill_en && (fill_idx == IDX_W'(g));
    assign sel_st   = st_en   && (st_idx   == IDX_W'(g));
    assign sel_inv  = inv_en  && (inv_idx  == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (clr_all) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (sel_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
      end else if (sel_inv) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (sel_st) begin
        dirty_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        tag_q[g]  <= fill_tag;
        data_q[g] <= fill_data;
      end else if (sel_st) begin
        data_q[g][st_ofs] <= st_byte;
      end
    end

    assign tag_o[g]  = tag_q[g];
    assign data_o[g] = data_q[g];
  end

  assign valid_o = valid_q;
  assign dirty_o = dirty_q;

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (valid_q[i] && (tag_q[i] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
  parameter int LINES = 2,
  parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_idx,
  input  logic [LINES-1:0]  valid_i,
  output logic [IDX_W-1:0]  victim_idx
);
  logic [IDX_W-1:0] age_q [LINES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(g))
          age_q[g] <= '0;
        else if (age_q[g] < touched_age)
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    victim_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (age_q[i] == IDX_W'(LINES - 1)) victim_idx = IDX_W'(i);
    found = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!valid_i[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int LINES  = 2,
  parameter int TAG_W  = 4,
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 1,
  parameter int IDX_W  = 1,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              flush,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [IDX_W-1:0]  victim_idx,
  input  logic [LINES-1:0]  valid_vec,
  input  logic [LINES-1:0]  dirty_vec,
  input  logic              mem_ack,
  output logic              req_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [IDX_W-1:0]  op_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              fill_en,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              inv_en,
  output logic              clr_all,
  output logic              acc_en,
  output logic              acc_store,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [OFS_W-1:0]  acc_ofs,
  output logic [BYTE_W-1:0] acc_byte,
  output logic              flush_done,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  wb_count
);
  wbc_state_e state_q, state_d;
  logic              q_we;
  logic [TAG_W-1:0]  q_tag;
  logic [OFS_W-1:0]  q_ofs;
  logic [BYTE_W-1:0] q_wdata;
  logic [IDX_W-1:0]  tgt_q, fidx_q;
  logic              cap_en, fidx_clr, fidx_inc;
  logic              hit_inc, miss_inc, wb_inc, done_d, done_q;
  logic              last_line;

  assign last_line = (fidx_q == IDX_W'(LINES - 1));

  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    op_idx    = tgt_q;
    fill_en   = 1'b0;
    inv_en    = 1'b0;
    clr_all   = 1'b0;
    acc_en    = 1'b0;
    acc_store = q_we;
    acc_idx   = tgt_q;
    acc_ofs   = q_ofs;
    acc_byte  = q_wdata;
    cap_en    = 1'b0;
    fidx_clr  = 1'b0;
    fidx_inc  = 1'b0;
    hit_inc   = 1'b0;
    miss_inc  = 1'b0;
    wb_inc    = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = !flush;
        acc_store = req_we;
        acc_idx   = lk_idx;
        acc_ofs   = req_ofs;
        acc_byte  = req_wdata;
        if (flush) begin
          fidx_clr = 1'b1;
          state_d  = ST_FSCAN;
        end else if (req_valid) begin
          if (lk_hit) begin
            hit_inc = 1'b1;
            acc_en  = 1'b1;
          end else begin
            miss_inc = 1'b1;
            cap_en   = 1'b1;
            if (valid_vec[victim_idx] && dirty_vec[victim_idx]) begin
              state_d = ST_WRITEBACK;
            end else begin
              state_d = ST_FILL;
            end
          end
        end
      end
      ST_WRITEBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          inv_en  = 1'b1;
          wb_inc  = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        acc_en  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FSCAN, ST_FWB: begin
        op_idx = fidx_q;
        if (state_q == ST_FSCAN && valid_vec[fidx_q] && dirty_vec[fidx_q]) begin
          state_d = ST_FWB;
        end else if (state_q == ST_FSCAN || mem_ack) begin
          mem_req = (state_q == ST_FWB);
          mem_we  = (state_q == ST_FWB);
          wb_inc  = (state_q == ST_FWB);
          if (last_line) begin
            clr_all = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            fidx_inc = 1'b1;
            state_d  = ST_FSCAN;
          end
        end else begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fidx_q     <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      wb_count   <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (fidx_clr)      fidx_q <= '0;
      else if (fidx_inc) fidx_q <= fidx_q + 1'b1;
      if (hit_inc)  hit_count  <= hit_count + 1'b1;
      if (miss_inc) miss_count <= miss_count + 1'b1;
      if (wb_inc)   wb_count   <= wb_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      q_we    <= req_we;
      q_tag   <= req_tag;
      q_ofs   <= req_ofs;
      q_wdata <= req_wdata;
      tgt_q   <= victim_idx;
    end
  end

  assign fill_tag   = q_tag;
  assign tgt_idx    = tgt_q;
  assign flush_done = done_q;
endmodule

// File: rtl/wbc_top.sv
module wbc_top
  import wbc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 2,
  parameter int LINES     = 2,
  parameter int CNT_W     = 16,
  localparam int OFS_W    = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1,
  localparam int TAG_W    = ADDR_W - OFS_W,
  localparam int BLK_W    = BYTE_W * BLK_BYTES,
  localparam int IDX_W    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [BYTE_W-1:0] resp_rdata,
  input  logic              flush,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TAG_W-1:0]  mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  wb_count
);
  logic [TAG_W-1:0]  req_tag, fill_tag;
  logic [OFS_W-1:0]  req_ofs, acc_ofs;
  logic              lk_hit, fill_en, inv_en, clr_all, acc_en, acc_store;
  logic [IDX_W-1:0]  lk_idx, victim_idx, op_idx, tgt_idx, acc_idx;
  logic [BYTE_W-1:0] acc_byte, line_byte;
  logic [LINES-1:0]  valid_vec, dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [BLK_BYTES-1:0][BYTE_W-1:0] data_arr [LINES];
  logic              resp_valid_q;
  logic [BYTE_W-1:0] resp_data_q;

  assign req_tag = req_addr[ADDR_W-1:OFS_W];
  assign req_ofs = req_addr[OFS_W-1:0];

  wbc_lines #(
    .LINES(LINES), .TAG_W(TAG_W), .BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES),
    .IDX_W(IDX_W), .OFS_W(OFS_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(req_tag), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .fill_en(fill_en), .fill_idx(tgt_idx), .fill_tag(fill_tag), .fill_data(mem_rdata),
    .st_en(acc_en && acc_store), .st_idx(acc_idx), .st_ofs(acc_ofs), .st_byte(acc_byte),
    .inv_en(inv_en), .inv_idx(tgt_idx), .clr_all(clr_all),
    .valid_o(valid_vec), .dirty_o(dirty_vec), .tag_o(tag_arr), .data_o(data_arr)
  );

  wbc_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(acc_en), .touch_idx(acc_idx),
    .valid_i(valid_vec), .victim_idx(victim_idx)
  );

  wbc_ctrl #(
    .LINES(LINES), .TAG_W(TAG_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_tag(req_tag), .req_ofs(req_ofs),
    .req_wdata(req_wdata), .flush(flush),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .victim_idx(victim_idx),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec), .mem_ack(mem_ack),
    .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we), .op_idx(op_idx),
    .fill_tag(fill_tag), .fill_en(fill_en), .tgt_idx(tgt_idx), .inv_en(inv_en),
    .clr_all(clr_all), .acc_en(acc_en), .acc_store(acc_store), .acc_idx(acc_idx),
    .acc_ofs(acc_ofs), .acc_byte(acc_byte), .flush_done(flush_done),
    .hit_count(hit_count), .miss_count(miss_count), .wb_count(wb_count)
  );

  assign mem_addr  = mem_we ? tag_arr[op_idx] : fill_tag;
  assign mem_wdata = data_arr[op_idx];
  assign line_byte = data_arr[acc_idx][acc_ofs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid_q <= 1'b0;
    else        resp_valid_q <= acc_en;
  end

  always_ff @(posedge clk) begin
    if (acc_en) resp_data_q <= acc_store ? acc_byte : line_byte;
  end

  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_data_q;
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [TAG_W-1:0] mem_addr,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] wb_count,
  input logic             flush_done
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R7
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1)); // R8
  AST_WB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_count != $past(wb_count)) |-> $past(mem_req && mem_we && mem_ack)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done); // R9
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !mem_req); // R9
endmodule

bind wbc_top wbc_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .hit_count(hit_count), .wb_count(wb_count), .flush_done(flush_done)
);

// File: tb/sim_wbc_top.sv
module sim_wbc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we, flush, mem_ack;
  logic [4:0]  req_addr;
  logic [7:0]  req_wdata;
  logic [15:0] mem_rdata;
  logic        req_ready, resp_valid, flush_done, mem_req, mem_we;
  logic [7:0]  resp_rdata;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] hit_count, miss_count, wb_count;

  int n_vec = 0, n_bad = 0;
  logic [7:0] bmem [32];
  logic [7:0] rmem [32];
  logic [7:0] exp_q [$];
  logic       op_w [$];
  logic [3:0] op_a [$];
  bit         done_run = 0;

  always #4 clk = ~clk;

  wbc_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .flush(flush),
    .flush_done(flush_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count),
    .wb_count(wb_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    case (i)
      0: return 8'd78;   1: return 8'd29;   2: return 8'd120;  3: return 8'd123;
      4: return 8'd71;   5: return 8'd150;  6: return 8'd162;  7: return 8'd173;
      8: return 8'd18;   9: return 8'd21;   10: return 8'd33;  11: return 8'd28;
      12: return 8'd19;  13: return 8'd200; 14: return 8'd210; 15: return 8'd225;
      default: return 8'(i * 3);
    endcase
  endfunction

  // driver: issues one request and pushes the expected response
  task automatic do_req(input logic we, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (we) begin exp_q.push_back(d); rmem[a] = d; end
    else    exp_q.push_back(rmem[a]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && (exp_q.size() != 0 || !req_ready); k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares responses against the scoreboard (R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected response", 1, 0);
        else check("R2/R3/R4 response data", int'(resp_rdata), int'(exp_q.pop_front()));
      end
    end
  end

  // memory model: acks after a short wait, logs every transfer
  initial begin
    int lat = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        check("R7 ready low during memory transfer", int'(req_ready), 0);
        if (lat == 2) begin
          lat = 0;
          mem_ack = 1'b1;
          op_w.push_back(mem_we);
          op_a.push_back(mem_addr);
          if (mem_we) begin
            bmem[{mem_addr, 1'b0}] = mem_wdata[7:0];
            bmem[{mem_addr, 1'b1}] = mem_wdata[15:8];
          end else begin
            mem_rdata = {bmem[{mem_addr, 1'b1}], bmem[{mem_addr, 1'b0}]};
          end
        end else lat++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int nlog;
    int nw;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; flush = 1'b0;
    for (int i = 0; i < 32; i++) begin bmem[i] = init_val(i); rmem[i] = init_val(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 no response after reset", int'(resp_valid), 0);
    check("R1 no memory request after reset", int'(mem_req), 0);
    check("R1 counters zero", int'(hit_count) + int'(miss_count) + int'(wb_count), 0);

    // R10 access sequence
    do_req(0, 5'd1, 8'd0);
    do_req(0, 5'd7, 8'd0);
    do_req(1, 5'd0, 8'd173);
    do_req(1, 5'd5, 8'd29);
    do_req(0, 5'd10, 8'd0);
    do_req(1, 5'd5, 8'd29);
    do_req(1, 5'd10, 8'd29);
    drain();
    check("R10 misses", int'(miss_count), 4);
    check("R10 hits", int'(hit_count), 3);
    check("R10 writebacks", int'(wb_count), 1);
    check("R8 writeback counter matches writes", int'(wb_count), 1);
    check("R4 first transfer is a read", int'(op_w[0]), 0);
    check("R4 first read block address", int'(op_a[0]), 0);
    nw = 0;
    for (int i = 0; i < op_w.size(); i++) begin
      if (op_w[i]) begin
        nw++;
        check("R5 dirty victim block address", int'(op_a[i]), 0);
        check("R5 fill read follows write", int'(op_w[i+1]), 0);
        check("R5 fill read block address", int'(op_a[i+1]), 5);
      end
    end
    check("R5 exactly one memory write", nw, 1);
    check("R5 whole block written byte0", int'(bmem[0]), 173);
    check("R5 whole block written byte1", int'(bmem[1]), 29);
    check("R3 store hit not written through", int'(bmem[5]), 150);
    check("R3 store to address 10 kept in cache", int'(bmem[10]), 33);

    // R9 flush
    nlog = op_w.size();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    begin
      int k = 0;
      while (!flush_done && k < 100) begin @(negedge clk); k++; end
    end
    check("R9 flush done seen", int'(flush_done), 1);
    @(negedge clk);
    check("R9 done is one cycle", int'(flush_done), 0);
    check("R9 writebacks after flush", int'(wb_count), 3);
    check("R9 two flush writes", op_w.size() - nlog, 2);
    check("R9 line 0 written first", int'(op_a[nlog]), 5);
    check("R9 line 1 written second", int'(op_a[nlog+1]), 2);
    check("R9 block 2 contents", int'({bmem[5], bmem[4]}), int'({8'd29, 8'd71}));
    check("R9 block 5 contents", int'({bmem[11], bmem[10]}), int'({8'd28, 8'd29}));

    // R9 and R6: empty after flush, LRU selection
    do_req(0, 5'd10, 8'd0);
    drain();
    check("R9 access after flush misses", int'(miss_count), 5);
    do_req(0, 5'd1, 8'd0);
    do_req(0, 5'd10, 8'd0);
    drain();
    nlog = op_w.size();
    check("R2 hit count after re-touch", int'(hit_count), 4);
    do_req(0, 5'd3, 8'd0);
    drain();
    check("R5 clean victim not written", int'(wb_count), 3);
    check("R6 clean eviction only one read", op_w.size() - nlog, 1);
    nlog = op_w.size();
    do_req(0, 5'd11, 8'd0);
    drain();
    check("R6 recently used block retained", int'(hit_count), 5);
    check("R2 hit causes no memory traffic", op_w.size() - nlog, 0);
    check("R8 miss count", int'(miss_count), 7);
    // R3 store miss allocates and marks modified: evicted later as dirty
    do_req(1, 5'd20, 8'd99);
    do_req(0, 5'd10, 8'd0);
    do_req(0, 5'd30, 8'd0);
    drain();
    check("R3 store miss line written back on eviction", int'(bmem[20]), 99);
    check("R8 writebacks after store miss eviction", int'(wb_count), 4);
    check("R2/R3 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule